// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between a clock source and its output pins. It gates a bank of single-ended 33 MHz outputs and one differential output pair. It answers an active-low stop pin, a stop-run register bit, an active-low power-down pin and a set of per-output control bits: enable, free-run, stop-tristate and power-down-tristate. The block runs on one fast system clock. The raw source clocks arrive as level inputs: the free-running 33 MHz reference and the true leg of the differential source. The block senses their edges and produces registered, gated copies of them.

The stop request is sampled only on rising edges of the 33 MHz reference. Stoppable single-ended outputs then park low on their next falling edge. Only after all of them are parked does the differential pair park. It parks on its next true rising edge, or it tristates if configured to. Power-down must be seen low on two consecutive complement rising edges. It then parks every output and takes priority over stop. Each output also reports a two-bit state code that is recomputed every cycle.

Top module: `clk_stop_gate`

## Requirements
- R1: State codes are 0 = running, 1 = parked high, 2 = parked low, 3 = tristate. Single-ended outputs use 0, 2 and 3; the pair uses 0, 1 and 3. After reset, with every enable at 1, every output reports 0 and the pair drives both legs.
- R2: A stop request is the stop pin low or the stop-run bit at 0. It is sampled only at rising edges of the 33 MHz reference, so a pulse that covers no such edge has no effect.
- R3: A stoppable single-ended output parks low and reports 2. It leaves and re-enters the running state only at a falling edge of the reference, so every high pulse it drives has the full source width.
- R4: A single-ended output whose free-run bit is 1 ignores both stop sources and keeps toggling while reporting 0.
- R5: A stoppable pair parks only after every stoppable single-ended output is parked, and only at a true-leg rising edge. It then drives true high and complement low (code 1), or leaves both legs undriven (code 3) when its stop-tristate bit is 1.
- R6: A pair whose free-run bit is 1 ignores stop and keeps reporting 0.
- R7: When the stop request is withdrawn, every parked output returns to code 0 without a shortened pulse: single-ended outputs at a reference falling edge, the pair at a true rising edge.
- R8: Power-down takes effect only after the pin is seen low on 2 consecutive complement rising edges (true-leg falling edges). A shorter low pulse changes nothing.
- R9: In power-down every single-ended output parks low (code 2), free-run ones included. The pair drives true high with the complement undriven (code 1), or leaves both legs undriven (code 3) when its power-down-tristate bit is 1.
- R10: Power-down overrides stop: when both are active, the pair follows its power-down-tristate bit and ignores its stop-tristate bit.
- R11: An output whose enable bit is 0 reports 3 whatever the stop and power-down inputs are. A disabled single-ended output drives 0, and a disabled pair drives neither leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref33_i | input | 1 | Free-running 33 MHz reference level |
| dref_i | input | 1 | Differential source true-leg level |
| stop_n_i | input | 1 | Active-low stop pin |
| pwrdn_n_i | input | 1 | Active-low power-down pin |
| stop_run_i | input | 1 | Stop-run register bit, 0 requests stop |
| se_en_i | input | N_SE | Per-output enable of single-ended outputs |
| se_free_i | input | N_SE | Per-output free-run of single-ended outputs |
| df_en_i | input | 1 | Pair enable |
| df_free_i | input | 1 | Pair free-run |
| df_stop_tri_i | input | 1 | Pair tristates when stopped |
| df_pd_tri_i | input | 1 | Pair tristates in power-down |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| se_state_o | output | 2*N_SE | State codes, output i in bits 2i+1:2i |
| df_t_o | output | 1 | Pair true leg |
| df_c_o | output | 1 | Pair complement leg |
| df_t_oe_o | output | 1 | True leg driven |
| df_c_oe_o | output | 1 | Complement leg driven |
| df_state_o | output | 2 | Pair state code |

## Verification
The sweep steps through every free-run mask of four single-ended outputs. It crosses each mask with stop from the pin or from the register bit, with the pair's stop-tristate bit, and with the pair's free-run bit. These runs separate outputs that must park from outputs that must not, and parked-high from tristated pairs. Pulse-width monitors and recorded park cycles show whether parking and resume happen on the correct edges and in the correct group order. Short stop and power-down pulses placed between sampling edges check the sampling rules. Combined power-down with stop, and disabled outputs under both, check the priorities.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PARK_HI = 2'd1,
        ST_PARK_LO = 2'd2,
        ST_TRI     = 2'd3
    } out_state_e;

    typedef enum logic [1:0] {
        DM_RUN   = 2'd0,
        DM_STOP  = 2'd1,
        DM_PWRDN = 2'd2
    } diff_mode_e;
endpackage

// File: rtl/edge_sense.sv
`timescale 1ns/1ps
module edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } es_regs_t;

    es_regs_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    assign rise_o = lvl_i && !es_q.prev;
    assign fall_o = !lvl_i && es_q.prev;
endmodule

// File: rtl/pd_qualifier.sv
`timescale 1ns/1ps
module pd_qualifier #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic pd_n_i,
    output logic active_o
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] CMAX = CW'(QUAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pq_regs_t;

    pq_regs_t pq_d, pq_q;

    always_comb begin
        pq_d = pq_q;
        if (sample_i) begin
            if (pd_n_i)             pq_d.cnt = '0;
            else if (pq_q.cnt != CMAX) pq_d.cnt = pq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq_q <= '0;
        else        pq_q <= pq_d;
    end

    assign active_o = (pq_q.cnt == CMAX);

    // R8: power-down only becomes active after a low sample
    a_r8_pd_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> (!$past(pd_n_i) && $past(sample_i)));
endmodule

// File: rtl/se_gate.sv
`timescale 1ns/1ps
module se_gate
    import clkgate_pkg::*;
#(
    parameter int N = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              stop_i,
    input  logic              pd_i,
    input  logic [N-1:0]      en_i,
    input  logic [N-1:0]      free_i,
    output logic [N-1:0]      clk_o,
    output logic [N-1:0][1:0] st_o,
    output logic [N-1:0]      run_o
);
    typedef struct packed {
        logic [N-1:0]      run;
        logic [N-1:0]      clk;
        logic [N-1:0][1:0] st;
    } se_regs_t;

    se_regs_t se_d, se_q;

    always_comb begin
        se_d = se_q;
        for (int i = 0; i < N; i++) begin
            if (fall_i) se_d.run[i] = !pd_i && !(stop_i && !free_i[i]);
            se_d.clk[i] = en_i[i] && se_d.run[i] && lvl_i;
            if (!en_i[i])          se_d.st[i] = ST_TRI;
            else if (se_d.run[i])  se_d.st[i] = ST_RUN;
            else                   se_d.st[i] = ST_PARK_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se_q.run <= '1;
            se_q.clk <= '0;
            se_q.st  <= '0;
        end else begin
            se_q <= se_d;
        end
    end

    assign clk_o = se_q.clk;
    assign st_o  = se_q.st;
    assign run_o = se_q.run;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3: a gated high pulse only starts on a source rising edge
        a_r3_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(clk_o[g]) && $past(en_i[g]) && $past(en_i[g], 2)) |-> $past(rise_i));
        // R11: a disabled output is tristated and quiet
        a_r11_disabled_tri: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_i[g]) |-> (st_o[g] == ST_TRI && !clk_o[g]));
    end
endmodule

// File: rtl/df_gate.sv
`timescale 1ns/1ps
module df_gate
    import clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic       rise_i,
    input  logic       stop_i,
    input  logic       quiet_i,
    input  logic       pd_i,
    input  logic       en_i,
    input  logic       free_i,
    input  logic       stop_tri_i,
    input  logic       pd_tri_i,
    output logic       t_o,
    output logic       c_o,
    output logic       t_oe_o,
    output logic       c_oe_o,
    output logic [1:0] st_o
);
    typedef struct packed {
        diff_mode_e mode;
        logic       t;
        logic       c;
        logic       toe;
        logic       coe;
        logic [1:0] st;
    } df_regs_t;

    df_regs_t df_d, df_q;

    always_comb begin
        df_d = df_q;
        if (rise_i) begin
            if (pd_i)
                df_d.mode = DM_PWRDN;
            else if (stop_i && !free_i && (quiet_i || df_q.mode == DM_STOP))
                df_d.mode = DM_STOP;
            else
                df_d.mode = DM_RUN;
        end
        df_d.t   = 1'b0;
        df_d.c   = 1'b0;
        df_d.toe = 1'b0;
        df_d.coe = 1'b0;
        df_d.st  = ST_TRI;
        if (en_i) begin
            case (df_d.mode)
                DM_STOP: begin
                    if (!stop_tri_i) begin
                        df_d.t   = 1'b1;
                        df_d.toe = 1'b1;
                        df_d.coe = 1'b1;
                        df_d.st  = ST_PARK_HI;
                    end
                end
                DM_PWRDN: begin
                    if (!pd_tri_i) begin
                        df_d.t   = 1'b1;
                        df_d.toe = 1'b1;
                        df_d.st  = ST_PARK_HI;
                    end
                end
                default: begin
                    df_d.t   = lvl_i;
                    df_d.c   = !lvl_i;
                    df_d.toe = 1'b1;
                    df_d.coe = 1'b1;
                    df_d.st  = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            df_q.mode <= DM_RUN;
            df_q.t    <= 1'b0;
            df_q.c    <= 1'b0;
            df_q.toe  <= 1'b1;
            df_q.coe  <= 1'b1;
            df_q.st   <= ST_RUN;
        end else begin
            df_q <= df_d;
        end
    end

    assign t_o    = df_q.t;
    assign c_o    = df_q.c;
    assign t_oe_o = df_q.toe;
    assign c_oe_o = df_q.coe;
    assign st_o   = df_q.st;

    // R5: the pair enters the stopped mode only once the single-ended bank is quiet
    a_r5_after_se_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (df_q.mode == DM_STOP && $past(df_q.mode) != DM_STOP) |-> ($past(quiet_i) && $past(rise_i)));
    // R9: power-down mode is entered only on a true rising edge while power-down is qualified
    a_r9_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (df_q.mode == DM_PWRDN && $past(df_q.mode) != DM_PWRDN) |-> ($past(pd_i) && $past(rise_i)));
    // R11: a disabled pair drives neither leg
    a_r11_pair_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!t_oe_o && !c_oe_o && st_o == ST_TRI));
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter int N_SE    = 10,
    parameter int PD_QUAL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref33_i,
    input  logic              dref_i,
    input  logic              stop_n_i,
    input  logic              pwrdn_n_i,
    input  logic              stop_run_i,
    input  logic [N_SE-1:0]   se_en_i,
    input  logic [N_SE-1:0]   se_free_i,
    input  logic              df_en_i,
    input  logic              df_free_i,
    input  logic              df_stop_tri_i,
    input  logic              df_pd_tri_i,
    output logic [N_SE-1:0]   se_clk_o,
    output logic [2*N_SE-1:0] se_state_o,
    output logic              df_t_o,
    output logic              df_c_o,
    output logic              df_t_oe_o,
    output logic              df_c_oe_o,
    output logic [1:0]        df_state_o
);
    typedef struct packed {
        logic stop_smp;
    } top_regs_t;

    top_regs_t top_d, top_q;

    logic ref_rise, ref_fall, dref_rise, dref_fall;
    logic pd_act, se_quiet;
    logic [N_SE-1:0]      se_run;
    logic [N_SE-1:0][1:0] se_st;

    edge_sense u_ref_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ref33_i),
        .rise_o (ref_rise),
        .fall_o (ref_fall)
    );

    edge_sense u_dref_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (dref_i),
        .rise_o (dref_rise),
        .fall_o (dref_fall)
    );

    always_comb begin
        top_d = top_q;
        if (ref_rise) top_d.stop_smp = !stop_n_i || !stop_run_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    pd_qualifier #(.QUAL(PD_QUAL)) u_pdq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (dref_fall),
        .pd_n_i   (pwrdn_n_i),
        .active_o (pd_act)
    );

    se_gate #(.N(N_SE)) u_se (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ref33_i),
        .rise_i (ref_rise),
        .fall_i (ref_fall),
        .stop_i (top_q.stop_smp),
        .pd_i   (pd_act),
        .en_i   (se_en_i),
        .free_i (se_free_i),
        .clk_o  (se_clk_o),
        .st_o   (se_st),
        .run_o  (se_run)
    );

    assign se_quiet   = &(~se_run | se_free_i);
    assign se_state_o = se_st;

    df_gate u_df (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (dref_i),
        .rise_i     (dref_rise),
        .stop_i     (top_q.stop_smp),
        .quiet_i    (se_quiet),
        .pd_i       (pd_act),
        .en_i       (df_en_i),
        .free_i     (df_free_i),
        .stop_tri_i (df_stop_tri_i),
        .pd_tri_i   (df_pd_tri_i),
        .t_o        (df_t_o),
        .c_o        (df_c_o),
        .t_oe_o     (df_t_oe_o),
        .c_oe_o     (df_c_oe_o),
        .st_o       (df_state_o)
    );
endmodule

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;
    localparam int N = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int   cyc = 0;
    logic ref33 = 1'b1;
    logic dref = 1'b1;
    logic rst_n = 1'b0;
    logic stop_n = 1'b1, pd_n = 1'b1, stop_run = 1'b1;
    logic [N-1:0] se_en = '1, se_free = '0;
    logic df_en = 1'b1, df_free = 1'b0, df_stri = 1'b0, df_ptri = 1'b0;
    logic [N-1:0] se_clk;
    logic [2*N-1:0] se_state;
    logic df_t, df_c, df_toe, df_coe;
    logic [1:0] df_state;

    clk_stop_gate #(.N_SE(N), .PD_QUAL(2)) dut (
        .clk(clk), .rst_n(rst_n), .ref33_i(ref33), .dref_i(dref),
        .stop_n_i(stop_n), .pwrdn_n_i(pd_n), .stop_run_i(stop_run),
        .se_en_i(se_en), .se_free_i(se_free), .df_en_i(df_en),
        .df_free_i(df_free), .df_stop_tri_i(df_stri), .df_pd_tri_i(df_ptri),
        .se_clk_o(se_clk), .se_state_o(se_state), .df_t_o(df_t), .df_c_o(df_c),
        .df_t_oe_o(df_toe), .df_c_oe_o(df_coe), .df_state_o(df_state)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // source clocks: reference period 8 cycles, pair period 4 cycles
    always @(negedge clk) begin
        cyc   <= cyc + 1;
        ref33 <= ((cyc + 1) % 8) < 4;
        dref  <= ((cyc + 1) % 4) < 2;
    end

    // pulse-width and ordering monitors
    bit mon_on = 0;
    logic [N-1:0] se_prev = '0;
    int hi_cnt[N];
    bit armed[N];
    int rise_cnt[N];
    logic [1:0] st_prev[N];
    logic [1:0] mst;
    logic [1:0] df_st_prev = 2'd0;
    int lo_cnt = 0;
    bit t_armed = 0;
    int se_park_cyc = -1, df_park_cyc = -1;

    always @(negedge clk) begin
        if (!mon_on) begin
            for (int i = 0; i < N; i++) begin armed[i] = 0; hi_cnt[i] = 0; end
            t_armed = 0;
            lo_cnt  = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                mst = se_state[2*i +: 2];
                if (mst == 2'd3) armed[i] = 0;
                else if (se_clk[i] && !se_prev[i]) begin
                    armed[i] = 1; hi_cnt[i] = 1; rise_cnt[i]++;
                end else if (se_clk[i]) hi_cnt[i]++;
                else if (se_prev[i] && armed[i]) check("R3 pulse width", hi_cnt[i], 4);
                if (mst == 2'd2 && st_prev[i] != 2'd2) se_park_cyc = cyc;
                st_prev[i] = mst;
            end
            if (!df_toe) begin t_armed = 0; lo_cnt = 0; end
            else if (!df_t) lo_cnt++;
            else begin
                if (t_armed && lo_cnt != 0) check("R5 true leg low width", lo_cnt, 2);
                t_armed = 1;
                lo_cnt  = 0;
            end
            if (df_state != 2'd0 && df_st_prev == 2'd0) df_park_cyc = cyc;
            df_st_prev = df_state;
        end
        se_prev = se_clk;
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic check_all_run(input string req);
        for (int i = 0; i < N; i++) check(req, int'(se_state[2*i +: 2]), 0);
        check(req, int'(df_state), 0);
    endtask

    task automatic count_not_run(input int n, output int bad);
        bad = 0;
        repeat (n) begin
            tick(1);
            for (int i = 0; i < N; i++) if (se_state[2*i +: 2] != 2'd0) bad++;
            if (df_state != 2'd0) bad++;
        end
    endtask

    initial begin
        int bad;
        for (int i = 0; i < N; i++) begin rise_cnt[i] = 0; st_prev[i] = 2'd0; end
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check_all_run("R1 reset state");
        check("R1 reset true oe", int'(df_toe), 1);
        check("R1 reset comp oe", int'(df_coe), 1);
        tick(20);
        mon_on = 1;
        tick(16);

        // sweep: free mask x stop source x stop-tristate x pair free-run
        for (int fm = 0; fm < 16; fm++) begin
            for (int k = 0; k < 8; k++) begin
                se_free = fm[N-1:0];
                df_stri = k[1];
                df_free = k[2];
                tick(16);
                se_park_cyc = -1;
                df_park_cyc = -1;
                if (k[0]) stop_run = 1'b0; else stop_n = 1'b0;
                tick(24);
                for (int i = 0; i < N; i++) rise_cnt[i] = 0;
                tick(24);
                for (int i = 0; i < N; i++) begin
                    // R4 free outputs keep running, others park low (R3)
                    check(fm[i] ? "R4 free state" : "R3 parked state",
                          int'(se_state[2*i +: 2]), fm[i] ? 0 : 2);
                    check("R4 toggling", int'(rise_cnt[i] > 0), int'(fm[i]));
                    if (!fm[i]) check("R3 parked low", int'(se_clk[i]), 0);
                end
                if (k[2]) check("R6 pair free-run", int'(df_state), 0);
                else if (k[1]) begin
                    check("R5 pair tristate", int'(df_state), 3);
                    check("R5 legs undriven", int'({df_toe, df_coe}), 0);
                end else begin
                    check("R5 pair parked", int'(df_state), 1);
                    check("R5 legs t1 c0", int'({df_t, df_c, df_toe, df_coe}), 4'b1011);
                end
                if (!k[2] && fm != 15) begin
                    check("R5 order se parked", int'(se_park_cyc >= 0), 1);
                    check("R5 order pair later", int'(df_park_cyc > se_park_cyc), 1);
                end
                // R2: register bit path and pin path both released
                stop_run = 1'b1;
                stop_n   = 1'b1;
                tick(40);
                check_all_run("R7 resume");
            end
        end
        se_free = '0;
        df_free = 1'b0;
        df_stri = 1'b0;
        tick(16);

        // R2: stop pulse covering no reference rising edge is ignored
        do tick(1); while (cyc % 8 != 2);
        stop_n = 1'b0;
        tick(4);
        stop_n = 1'b1;
        count_not_run(32, bad);
        check("R2 short stop ignored", bad, 0);

        // R8: power-down low for a single qualifying sample is ignored
        do tick(1); while (cyc % 4 != 3);
        pd_n = 1'b0;
        tick(4);
        pd_n = 1'b1;
        count_not_run(32, bad);
        check("R8 single sample ignored", bad, 0);
        pd_n = 1'b0;
        tick(2);
        check_all_run("R8 not yet qualified");
        pd_n = 1'b1;
        tick(24);

        // R9/R10: power-down with stop also active
        for (int p = 0; p < 2; p++) begin
            se_free = 4'b1010;
            df_stri = 1'b1;
            df_ptri = p[0];
            stop_n  = 1'b0;
            pd_n    = 1'b0;
            tick(48);
            for (int i = 0; i < N; i++) begin
                check("R9 se parked low", int'(se_state[2*i +: 2]), 2);
                check("R9 se low", int'(se_clk[i]), 0);
            end
            check("R10 pair state", int'(df_state), p ? 3 : 1);
            check("R9 true oe", int'(df_toe), p ? 0 : 1);
            check("R9 comp undriven", int'(df_coe), 0);
            if (!p) check("R9 true high", int'(df_t), 1);
            stop_n = 1'b1;
            pd_n   = 1'b1;
            tick(48);
            check_all_run("R7 resume after power-down");
        end
        se_free = '0;
        df_stri = 1'b0;
        df_ptri = 1'b0;

        // R11: disabled outputs tristate under stop and power-down
        se_en = 4'b1110;
        df_en = 1'b0;
        stop_n = 1'b0;
        tick(48);
        check("R11 se disabled under stop", int'(se_state[1:0]), 3);
        check("R11 se disabled low", int'(se_clk[0]), 0);
        check("R11 pair disabled", int'(df_state), 3);
        check("R11 pair undriven", int'({df_toe, df_coe}), 0);
        pd_n = 1'b0;
        tick(48);
        check("R11 se disabled under power-down", int'(se_state[1:0]), 3);
        check("R11 pair disabled under power-down", int'(df_state), 3);
        stop_n = 1'b1;
        pd_n   = 1'b1;
        tick(48);
        check("R11 se disabled while running", int'(se_state[1:0]), 3);
        check("R11 pair disabled while running", int'(df_state), 3);
        se_en = '1;
        df_en = 1'b1;
        tick(48);
        check_all_run("R11 re-enabled");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule